// File: doc/BRIEF.md
# Configurable Pad Input/Output Cell

This block joins one bidirectional pad to the internal logic. A handful of configuration inputs choose how the pad value is handed to the fabric and whether, and under which control, the pad is driven. On the input side the pad value can go straight through, or be captured by a flop or a transparent latch. Capture is timed by one of several I/O clock lines, each treated as a level/strobe in the system clock domain.

On the output side the driven value can be inverted, so the pad can be active high or active low. The driver can be held off, held on, or made three-state. In the three-state case, one of four sources decides when it drives: a local enable from a logic block, either of two chip-wide output enables, or a constant on. The fabric input always reads the pad, so when the cell drives, it reads back its own value.

An active-low chip reset clears the captured value. Each cell is instanced once per pin, and every cell shares the global enables and I/O clock lines.

Top module: `iocell_top`

## Requirements
- R1: With capMode 0 (or the spare code 3), fabricIn equals the pad level in the same cycle, with no clock edge involved.
- R2: With capMode 1, fabricIn shows a stored bit. That bit takes the pad level at each rising clk edge at which the selected I/O clock line is 1, and it keeps its value at every other edge.
- R3: With capMode 2, fabricIn follows the pad while the selected I/O clock line is 1. While the line is 0, fabricIn shows the pad level taken at the last rising clk edge at which the line was 1.
- R4: The selected I/O clock line is ioClk[clkSel]; the other lines have no effect on capture.
- R5: While rstN is 0, the stored bit is 0, so fabricIn reads 0 in capMode 1 and in capMode 2. Clearing is asynchronous and takes effect without a clock edge.
- R6: With drvMode 0 (input only) or the spare code 3, the cell never drives the pad, whatever the enables and data are.
- R7: With drvMode 1 (output only), the cell always drives the pad, and fabricIn still reads the pad.
- R8: The driven level is dataOut when invertOut is 0 and the complement of dataOut when invertOut is 1.
- R9: With drvMode 2 (three-state), the cell drives the pad only while the enable chosen by oeSel is 1. The codes are: 0 is localOe, 1 is globalOe[0], 2 is globalOe[1], and 3 is always driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all capture happens on its rising edge |
| rstN | input | 1 | Active-low asynchronous clear of the captured bit |
| ioClk | input | NUM_IOCLK | I/O clock lines shared by all cells |
| clkSel | input | SEL_W | Index of the I/O clock line used by this cell |
| capMode | input | 2 | Input capture: 0 direct, 1 flop, 2 latch, 3 direct |
| drvMode | input | 2 | Output: 0 off, 1 always on, 2 three-state, 3 off |
| oeSel | input | 2 | Enable source in three-state: 0 local, 1 global 0, 2 global 1, 3 on |
| invertOut | input | 1 | 1 drives the complement of dataOut |
| dataOut | input | 1 | Value from the fabric to be driven |
| localOe | input | 1 | Enable from a logic block |
| globalOe | input | 2 | Chip-wide output enables |
| fabricIn | output | 1 | Pad value handed to the fabric |
| pad | inout | 1 | Three-state pad |

## Verification
The pad level, the direct path and the open latch all settle in the same cycle as their inputs, so they are due combinationally. The flop and the held latch value reflect the pad as it stood at the previous rising edge with the selected line high, which is one edge later. The bench changes every input on the falling edge and samples one nanosecond before the next rising edge. It compares against a bench model whose stored bit is updated only at rising edges, with the selected line and reset state as they stood then. When the cell is not expected to drive, the bench drives the pad against the cell's would-be value, so any stray drive shows up on the pad.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic [1:0] {
    CAP_DIRECT = 2'd0,
    CAP_FLOP   = 2'd1,
    CAP_LATCH  = 2'd2,
    CAP_SPARE  = 2'd3
  } capMode_e;

  typedef enum logic [1:0] {
    DRV_OFF    = 2'd0,
    DRV_ON     = 2'd1,
    DRV_TRI    = 2'd2,
    DRV_SPARE  = 2'd3
  } drvMode_e;

  typedef enum logic [1:0] {
    OE_LOCAL   = 2'd0,
    OE_GLOBAL0 = 2'd1,
    OE_GLOBAL1 = 2'd2,
    OE_FORCE   = 2'd3
  } oeSrc_e;

  localparam int NUM_GOE = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic driveEn;
    logic selClkHi;
    logic useFlop;
    logic useLatch;
    logic invert;
  } ioStrobe_t;

endpackage

// File: rtl/iocell_ctrl.sv
module iocell_ctrl
  import iocell_pkg::*;
#(
  parameter int NUM_IOCLK = 2,
  localparam int SEL_W = (NUM_IOCLK > 1) ? $clog2(NUM_IOCLK) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IOCLK-1:0] ioClk,
  input  logic [SEL_W-1:0]     clkSel,
  input  logic [1:0]           capMode,
  input  logic [1:0]           drvMode,
  input  logic [1:0]           oeSel,
  input  logic                 invertOut,
  input  logic                 localOe,
  input  logic [NUM_GOE-1:0]   globalOe,
  output ioStrobe_t            strb
);

  capMode_e capSel;
  drvMode_e drvSel;
  oeSrc_e   oeSrc;
  logic     oeLevel;

  assign capSel = capMode_e'(capMode);
  assign drvSel = drvMode_e'(drvMode);
  assign oeSrc  = oeSrc_e'(oeSel);

  always_comb begin
    unique case (oeSrc)
      OE_LOCAL:   oeLevel = localOe;
      OE_GLOBAL0: oeLevel = globalOe[0];
      OE_GLOBAL1: oeLevel = globalOe[1];
      default:    oeLevel = 1'b1;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.selClkHi = ioClk[clkSel];
    strb.useFlop  = (capSel == CAP_FLOP);
    strb.useLatch = (capSel == CAP_LATCH);
    strb.invert   = invertOut;
    unique case (drvSel)
      DRV_ON:  strb.driveEn = 1'b1;
      DRV_TRI: strb.driveEn = oeLevel;
      default: strb.driveEn = 1'b0;
    endcase
  end

  // R6: input-only codes never enable the driver
  a_r6_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    ((drvMode == DRV_OFF) || (drvMode == DRV_SPARE)) |-> !strb.driveEn);

  // R9: local enable source
  a_r9_local_oe: assert property (@(posedge clk) disable iff (!rstN)
    ((drvMode == DRV_TRI) && (oeSel == OE_LOCAL)) |-> (strb.driveEn == localOe));

  // R9: second global enable source
  a_r9_global1_oe: assert property (@(posedge clk) disable iff (!rstN)
    ((drvMode == DRV_TRI) && (oeSel == OE_GLOBAL1)) |-> (strb.driveEn == globalOe[1]));

endmodule

// File: rtl/iocell_datapath.sv
module iocell_datapath
  import iocell_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ioStrobe_t strb,
  input  logic      padIn,
  input  logic      dataOut,
  output logic      outVal,
  output logic      fabricIn
);

  logic holdQ;

  // one stored bit serves both the flop and the latch hold value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
    end else if (strb.selClkHi) begin
      holdQ <= padIn;
    end
  end

  always_comb begin
    if (strb.useFlop) begin
      fabricIn = holdQ;
    end else if (strb.useLatch) begin
      fabricIn = (rstN && strb.selClkHi) ? padIn : holdQ;
    end else begin
      fabricIn = padIn;
    end
  end

  assign outVal = dataOut ^ strb.invert;

  // R2: a high capture line loads the pad at the edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.selClkHi |=> (holdQ == $past(padIn)));

  // R3: a low capture line keeps the stored bit
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selClkHi |=> $stable(holdQ));

  // R5: reset keeps the stored bit cleared
  always @(posedge clk) begin
    if (!rstN) begin
      a_r5_clear: assert (holdQ == 1'b0);
    end
  end

endmodule

// File: rtl/iocell_top.sv
module iocell_top
  import iocell_pkg::*;
#(
  parameter int NUM_IOCLK = 2,
  localparam int SEL_W = (NUM_IOCLK > 1) ? $clog2(NUM_IOCLK) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IOCLK-1:0] ioClk,
  input  logic [SEL_W-1:0]     clkSel,
  input  logic [1:0]           capMode,
  input  logic [1:0]           drvMode,
  input  logic [1:0]           oeSel,
  input  logic                 invertOut,
  input  logic                 dataOut,
  input  logic                 localOe,
  input  logic [1:0]           globalOe,
  output logic                 fabricIn,
  inout  wire                  pad
);

  ioStrobe_t strb;
  logic      outVal;
  logic      padIn;

  iocell_ctrl #(.NUM_IOCLK(NUM_IOCLK)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ioClk     (ioClk),
    .clkSel    (clkSel),
    .capMode   (capMode),
    .drvMode   (drvMode),
    .oeSel     (oeSel),
    .invertOut (invertOut),
    .localOe   (localOe),
    .globalOe  (globalOe),
    .strb      (strb)
  );

  iocell_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .padIn    (padIn),
    .dataOut  (dataOut),
    .outVal   (outVal),
    .fabricIn (fabricIn)
  );

  assign pad   = strb.driveEn ? outVal : 1'bz;
  assign padIn = pad;

  // R7, R8: output-only mode drives the polarity-adjusted data
  a_r7_always_drive: assert property (@(posedge clk) disable iff (!rstN)
    (drvMode == DRV_ON) |-> (strb.driveEn && (outVal == (dataOut ^ invertOut))));

endmodule

// File: tb/tb_iocell_top.sv
`timescale 1ns/1ps
module tb_iocell_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] ioClk;
  logic [0:0] clkSel;
  logic [1:0] capMode, drvMode, oeSel;
  logic       invertOut, dataOut, localOe;
  logic [1:0] globalOe;
  logic       fabricIn;
  logic       tbDrv, tbVal;
  wire        pad;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic holdM;

  assign pad = tbDrv ? tbVal : 1'bz;

  always #2 clk = ~clk;

  iocell_top dut (
    .clk(clk), .rstN(rstN), .ioClk(ioClk), .clkSel(clkSel),
    .capMode(capMode), .drvMode(drvMode), .oeSel(oeSel),
    .invertOut(invertOut), .dataOut(dataOut), .localOe(localOe),
    .globalOe(globalOe), .fabricIn(fabricIn), .pad(pad)
  );

  function automatic logic expDrive();
    logic en;
    case (oeSel)
      2'd0: en = localOe;
      2'd1: en = globalOe[0];
      2'd2: en = globalOe[1];
      default: en = 1'b1;
    endcase
    if (drvMode == 2'd1) return 1'b1;
    if (drvMode == 2'd2) return en;
    return 1'b0;
  endfunction

  function automatic logic expPad();
    return expDrive() ? (dataOut ^ invertOut) : tbVal;
  endfunction

  function automatic logic expFab();
    logic hi;
    hi = ioClk[clkSel];
    if (capMode == 2'd1) return holdM;
    if (capMode == 2'd2) return (rstN && hi) ? expPad() : holdM;
    return expPad();
  endfunction

  function automatic string fabTag();
    string t;
    if (capMode == 2'd1) t = "R2";
    else if (capMode == 2'd2) t = "R3";
    else t = "R1";
    if (!rstN && (capMode == 2'd1 || capMode == 2'd2)) t = {t, "/R5"};
    if (clkSel == 1'b1) t = {t, "/R4"};
    return t;
  endfunction

  function automatic string padTag();
    string t;
    if (drvMode == 2'd1) t = "R7";
    else if (drvMode == 2'd2) t = "R9";
    else t = "R6";
    if (expDrive()) t = {t, "/R8"};
    return t;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs are already set at a falling edge; sample, then advance
  task automatic step();
    if (!rstN) holdM = 1'b0;
    // when the cell must not drive, contend against its would-be value
    tbDrv = !expDrive();
    if (tbDrv && ($urandom % 4 != 0)) tbVal = ~(dataOut ^ invertOut);
    #1;
    check(padTag(), pad, expPad());
    check(fabTag(), fabricIn, expFab());
    @(posedge clk);
    if (!rstN) holdM = 1'b0;
    else if (ioClk[clkSel]) holdM = expPad();
    @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] cm, input logic [1:0] dm,
                        input logic [1:0] os, input logic inv, input logic cs);
    capMode = cm; drvMode = dm; oeSel = os; invertOut = inv; clkSel = cs;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; ioClk = 2'b11; holdM = 1'b0;
    dataOut = 1'b1; localOe = 1'b0; globalOe = 2'b00;
    tbDrv = 1'b1; tbVal = 1'b1;
    setCfg(2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    // R5: reset state of flop capture with pad high
    step();
    step();
    rstN = 1'b1;

    // R2/R4: flop on line 1 only; line 0 toggles without effect
    setCfg(2'd1, 2'd0, 2'd0, 1'b0, 1'b1);
    ioClk = 2'b10; tbVal = 1'b1; step();
    ioClk = 2'b01; step();
    ioClk = 2'b01; step();

    // R3: latch transparent then holding
    setCfg(2'd2, 2'd0, 2'd0, 1'b0, 1'b0);
    ioClk = 2'b01; step();
    ioClk = 2'b00; step();
    step();

    // R7/R8: output only, both polarities, read back
    setCfg(2'd0, 2'd1, 2'd0, 1'b1, 1'b0);
    dataOut = 1'b0; step();
    invertOut = 1'b0; dataOut = 1'b1; step();

    // R9: each enable source, plus R6 with enables active
    setCfg(2'd0, 2'd2, 2'd1, 1'b0, 1'b0);
    globalOe = 2'b01; step();
    globalOe = 2'b10; step();
    oeSel = 2'd2; step();
    oeSel = 2'd3; globalOe = 2'b00; step();
    setCfg(2'd0, 2'd3, 2'd3, 1'b0, 1'b0); localOe = 1'b1; step();

    for (int i = 0; i < 4000; i++) begin
      if (i % 8 == 0)
        setCfg(2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      ioClk    = 2'($urandom);
      dataOut  = 1'($urandom);
      localOe  = 1'($urandom);
      globalOe = 2'($urandom);
      tbVal    = 1'($urandom);
      rstN     = ($urandom % 150 != 0);
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule